// File: doc/BRIEF.md
# Synchronized Reference and Feedback Ratio Divider

This block holds two programmable down-counters that feed a phase/frequency comparator in a frequency synthesizer. One counter divides reference count events by a ratio R. The other divides oscillator-feedback count events by a ratio N. Each counter emits a single-cycle strobe once per completed ratio, and the two strobe streams are the comparator's two inputs.

Both counters run on one common clock. Each one advances only when its own tick input is high, and each tick stands for one edge of the signal that counter divides. The ratio values come from a register interface. Committing a new N value is a synchronizing event. Both counters are forced to their current ratios on the same clock edge and then count down together. In the following cycle the block also asserts a one-cycle initialize strobe for the comparator. This keeps the two strobe streams phase-aligned right after retuning, which shortens acquisition. Writing R alone only takes effect at the R counter's next natural reload.

Top module: `ratio_divider_pair`

## Requirements
- R1: After reset, `ref_pulse`, `vco_pulse` and `det_init` are low. Both counters stay idle and emit no strobe, whatever the tick inputs do, until the first N commit.
- R2: When `n_commit` is high at a clock edge, `det_init` is high for exactly the following cycle.
- R3: A commit loads both counters on the same edge, each with its effective ratio. With one tick per cycle from the next edge on, the first `ref_pulse` appears R edges after the commit edge and the first `vco_pulse` appears N edges after it, and later strobes repeat every R and N ticks respectively.
- R4: A commit takes priority over a terminal-count reload in the same cycle. No strobe is issued in the cycle after a commit edge, and ticks present at the commit edge are not counted.
- R5: A counter moves only on edges where its tick input is high. A strobe lasts one cycle and follows the tick that finds the count at 1, after which the counter reloads its ratio.
- R6: A reference ratio of 1 is a bypass: every reference tick yields a `ref_pulse` one cycle later.
- R7: Reference ratios of 0, 2, 3 and 4 are not valid and behave as a ratio of 5. Ratios from 5 to 32767 are used as given.
- R8: Feedback ratios below 40 behave as 40. Ratios from 40 to 65535 are used as given.
- R9: Changing `r_value` without a commit triggers no load and no `det_init`. The feedback counter's phase is undisturbed, and the reference counter uses the new ratio from its next reload onward.
- R10: The largest ratios, 32767 for reference and 65535 for feedback, divide exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for both counters |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | Reference count event; advances the R counter |
| vco_tick | input | 1 | Feedback count event; advances the N counter |
| r_value | input | 15 | Programmed reference ratio |
| n_value | input | 16 | Programmed feedback ratio |
| n_commit | input | 1 | One-cycle strobe: new N written, jam-load both counters |
| ref_pulse | output | 1 | One-cycle divided-reference strobe |
| vco_pulse | output | 1 | One-cycle divided-feedback strobe |
| det_init | output | 1 | One-cycle comparator initialize strobe after a commit |

## Verification
The assertions assume that `n_commit` is a synchronous strobe. They also assume that the ratio inputs hold steady across any commit edge, so the values a counter loads are the effective values from the cycle before `det_init`. The bench changes `r_value` and `n_value` only at falling edges, together with or ahead of the commit. It never changes them in the commit's own cycle. The only exception is the mid-run R change, which is deliberately placed away from any commit. Tick inputs are driven as clean per-cycle levels, so each high level at a rising edge is exactly one count event.

// File: rtl/ratio_div_pkg.sv
package ratio_div_pkg;
   localparam int REF_WIDTH_DEF = 15;
   localparam int FB_WIDTH_DEF  = 16;
   localparam int REF_FLOOR_DEF = 5;
   localparam int FB_FLOOR_DEF  = 40;

   typedef enum logic [1:0] {
      CNT_IDLE = 2'd0,
      CNT_RUN  = 2'd1
   } cnt_state_e;
endpackage

// File: rtl/ratio_clamp.sv
module ratio_clamp #(
   parameter int W           = 16,
   parameter int FLOOR       = 40,
   parameter bit ALLOW_UNITY = 1'b0
) (
   input  logic [W-1:0] raw_i,
   output logic [W-1:0] eff_o
);
   localparam logic [W-1:0] FLOOR_V = W'(FLOOR);
   localparam logic [W-1:0] ONE_V   = W'(1);

   if (FLOOR < 2 || FLOOR >= (1 << W)) begin : g_bad_floor
      $error("ratio_clamp: FLOOR out of range for width");
   end

   if (ALLOW_UNITY) begin : g_unity
      always_comb begin
         if (raw_i == ONE_V)        eff_o = ONE_V;
         else if (raw_i < FLOOR_V)  eff_o = FLOOR_V;
         else                       eff_o = raw_i;
      end
   end else begin : g_floor_only
      always_comb begin
         if (raw_i < FLOOR_V) eff_o = FLOOR_V;
         else                 eff_o = raw_i;
      end
   end
endmodule

// File: rtl/jam_down_counter.sv
module jam_down_counter
   import ratio_div_pkg::*;
#(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         jam_i,
   input  logic         tick_i,
   input  logic [W-1:0] load_i,
   output logic [W-1:0] cnt_o,
   output logic         pulse_o
);
   localparam logic [W-1:0] ONE_V  = W'(1);
   localparam logic [W-1:0] ZERO_V = '0;

   if (W < 2) begin : g_bad_w
      $error("jam_down_counter: W must be at least 2");
   end

   cnt_state_e   state_q;
   logic [W-1:0] cnt_q;
   logic         pulse_q;
   logic         at_end;

   assign at_end = (cnt_q <= ONE_V);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= CNT_IDLE;
         cnt_q   <= ZERO_V;
         pulse_q <= 1'b0;
      end else if (jam_i) begin
         state_q <= CNT_RUN;
         cnt_q   <= load_i;
         pulse_q <= 1'b0;
      end else begin
         pulse_q <= 1'b0;
         if (state_q == CNT_RUN && tick_i) begin
            if (at_end) begin
               pulse_q <= 1'b1;
               cnt_q   <= load_i;
            end else begin
               cnt_q <= cnt_q - ONE_V;
            end
         end
      end
   end

   assign cnt_o   = cnt_q;
   assign pulse_o = pulse_q;

   AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == CNT_IDLE) |-> !pulse_o); // R1
   AST_JAM_BLOCKS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      jam_i |=> !pulse_o); // R4
   AST_STROBE_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_o |-> $past(tick_i)); // R5
   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == CNT_RUN) |-> (cnt_q != ZERO_V)); // R5
endmodule

// File: rtl/jam_sync_ctrl.sv
module jam_sync_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic commit_i,
   output logic jam_o,
   output logic init_o
);
   logic init_q;

   assign jam_o = commit_i;

   always_ff @(posedge clk) begin
      if (!rst_n) init_q <= 1'b0;
      else        init_q <= commit_i;
   end

   assign init_o = init_q;
endmodule

// File: rtl/ratio_divider_pair.sv
module ratio_divider_pair
   import ratio_div_pkg::*;
#(
   parameter int REF_W     = REF_WIDTH_DEF,
   parameter int FB_W      = FB_WIDTH_DEF,
   parameter int REF_FLOOR = REF_FLOOR_DEF,
   parameter int FB_FLOOR  = FB_FLOOR_DEF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ref_tick,
   input  logic             vco_tick,
   input  logic [REF_W-1:0] r_value,
   input  logic [FB_W-1:0]  n_value,
   input  logic             n_commit,
   output logic             ref_pulse,
   output logic             vco_pulse,
   output logic             det_init
);
   if (REF_FLOOR <= 1) begin : g_bad_ref_floor
      $error("ratio_divider_pair: REF_FLOOR must exceed 1");
   end

   logic [REF_W-1:0] r_eff, r_cnt;
   logic [FB_W-1:0]  n_eff, n_cnt;
   logic             jam;

   ratio_clamp #(.W(REF_W), .FLOOR(REF_FLOOR), .ALLOW_UNITY(1'b1)) u_ref_clamp (
      .raw_i(r_value), .eff_o(r_eff));

   ratio_clamp #(.W(FB_W), .FLOOR(FB_FLOOR), .ALLOW_UNITY(1'b0)) u_fb_clamp (
      .raw_i(n_value), .eff_o(n_eff));

   jam_sync_ctrl u_sync (
      .clk(clk), .rst_n(rst_n), .commit_i(n_commit), .jam_o(jam), .init_o(det_init));

   jam_down_counter #(.W(REF_W)) u_ref_cnt (
      .clk(clk), .rst_n(rst_n), .jam_i(jam), .tick_i(ref_tick),
      .load_i(r_eff), .cnt_o(r_cnt), .pulse_o(ref_pulse));

   jam_down_counter #(.W(FB_W)) u_fb_cnt (
      .clk(clk), .rst_n(rst_n), .jam_i(jam), .tick_i(vco_tick),
      .load_i(n_eff), .cnt_o(n_cnt), .pulse_o(vco_pulse));

   AST_JAM_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
      det_init |-> ((r_cnt == $past(r_eff)) && (n_cnt == $past(n_eff)))); // R3
   AST_INIT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      det_init |-> (!ref_pulse && !vco_pulse)); // R4
endmodule

// File: tb/ratio_divider_pair_tb.sv
module ratio_divider_pair_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ref_tick = 1'b0;
   logic        vco_tick = 1'b0;
   logic [14:0] r_value = '0;
   logic [15:0] n_value = '0;
   logic        n_commit = 1'b0;
   logic        ref_pulse, vco_pulse, det_init;

   int checks = 0;
   int failures = 0;

   always #2 clk = ~clk;

   ratio_divider_pair u_dut (
      .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .vco_tick(vco_tick),
      .r_value(r_value), .n_value(n_value), .n_commit(n_commit),
      .ref_pulse(ref_pulse), .vco_pulse(vco_pulse), .det_init(det_init));

   localparam int NV = 7;
   localparam int VR [NV] = '{10, 1, 3, 0, 2, 4, 300};
   localparam int VN [NV] = '{50, 40, 7, 100, 39, 0, 1000};
   localparam int ER [NV] = '{10, 1, 5, 5, 5, 5, 300};
   localparam int EN [NV] = '{50, 40, 40, 100, 40, 40, 1000};

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   // starts and ends at a falling edge
   task automatic commit(input int r, input int n);
      r_value  = 15'(r);
      n_value  = 16'(n);
      n_commit = 1'b1;
      ref_tick = 1'b1;
      vco_tick = 1'b1;
      @(posedge clk);
      @(negedge clk);
      n_commit = 1'b0;
      chk(det_init == 1'b1, "R2 det_init after commit", int'(det_init), 1);
      chk(!ref_pulse && !vco_pulse, "R4 no strobe after commit edge",
          int'(ref_pulse) + int'(vco_pulse), 0);
   endtask

   task automatic run_pair(input int limit, input int ref_every, input int vco_every,
                           input int chg_at, input int chg_val,
                           output int r1, output int r2, output int n1, output int n2,
                           output int dets, output int vdbl);
      bit prev_v;
      r1 = 0; r2 = 0; n1 = 0; n2 = 0; dets = 0; vdbl = 0; prev_v = 1'b0;
      for (int j = 1; j <= limit; j++) begin
         ref_tick = (ref_every != 0) && ((j - 1) % ref_every == 0);
         vco_tick = (vco_every != 0) && ((j - 1) % vco_every == 0);
         if (j == chg_at + 1) r_value = 15'(chg_val);
         @(posedge clk);
         @(negedge clk);
         if (ref_pulse) begin
            if (r1 == 0) r1 = j; else if (r2 == 0) r2 = j;
         end
         if (vco_pulse) begin
            if (n1 == 0) n1 = j; else if (n2 == 0) n2 = j;
            if (prev_v) vdbl++;
         end
         prev_v = vco_pulse;
         if (det_init) dets++;
      end
      ref_tick = 1'b0;
      vco_tick = 1'b0;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      int r1, r2, n1, n2, dets, vdbl;
      repeat (3) @(negedge clk);
      chk(!ref_pulse && !vco_pulse && !det_init, "R1 outputs low in reset",
          int'(ref_pulse) + int'(vco_pulse) + int'(det_init), 0);
      rst_n = 1'b1;
      r_value = 15'd5; n_value = 16'd40;
      run_pair(100, 1, 1, -1, 0, r1, r2, n1, n2, dets, vdbl);
      chk(r1 == 0 && n1 == 0 && dets == 0, "R1 idle before first commit",
          r1 + n1 + dets, 0);

      // table of ratio vectors, continuous ticks
      for (int v = 0; v < NV; v++) begin
         int lim;
         lim = 2 * ((ER[v] > EN[v]) ? ER[v] : EN[v]) + 3;
         commit(VR[v], VN[v]);
         run_pair(lim, 1, 1, -1, 0, r1, r2, n1, n2, dets, vdbl);
         chk(r1 == ER[v], $sformatf("R3/R6/R7 first ref strobe vec%0d", v), r1, ER[v]);
         chk(r2 == 2 * ER[v], $sformatf("R3/R6/R7 ref period vec%0d", v), r2, 2 * ER[v]);
         chk(n1 == EN[v], $sformatf("R3/R8 first vco strobe vec%0d", v), n1, EN[v]);
         chk(n2 == 2 * EN[v], $sformatf("R3/R8 vco period vec%0d", v), n2, 2 * EN[v]);
      end

      // R4: commit arrives when both counters sit at 1
      commit(5, 40);
      run_pair(39, 1, 1, -1, 0, r1, r2, n1, n2, dets, vdbl);
      chk(n1 == 0, "R4 setup no vco strobe yet", n1, 0);
      commit(5, 40);
      run_pair(45, 1, 1, -1, 0, r1, r2, n1, n2, dets, vdbl);
      chk(r1 == 5, "R4 ref restart after override", r1, 5);
      chk(n1 == 40, "R4 vco restart after override", n1, 40);

      // R5: tick gating and single-cycle strobes
      commit(5, 40);
      run_pair(85, 0, 2, -1, 0, r1, r2, n1, n2, dets, vdbl);
      chk(r1 == 0, "R5 no ref strobe without ticks", r1, 0);
      chk(n1 == 79, "R5 vco strobe after 40 alternate ticks", n1, 79);
      chk(vdbl == 0, "R5 strobe lasts one cycle", vdbl, 0);

      // R9: R change without commit
      commit(10, 50);
      run_pair(55, 1, 1, 3, 20, r1, r2, n1, n2, dets, vdbl);
      chk(dets == 0, "R9 no det_init on R write", dets, 0);
      chk(n1 == 50, "R9 vco phase undisturbed", n1, 50);
      chk(r1 == 10, "R9 current ref period completes", r1, 10);
      chk(r2 == 30, "R9 new ref ratio from next reload", r2, 30);

      // R10: largest ratios
      commit(32767, 65535);
      run_pair(65536, 1, 1, -1, 0, r1, r2, n1, n2, dets, vdbl);
      chk(r1 == 32767, "R10 max ref ratio", r1, 32767);
      chk(r2 == 65534, "R10 max ref period", r2, 65534);
      chk(n1 == 65535, "R10 max vco ratio", n1, 65535);

      summary();
   end
endmodule